// File: doc/BRIEF.md
# Inter-Processor Mailbox

The mailbox lets processors that share one register bus hand 32-bit words to each other. It contains several independent message queues. A sender stores a word by writing the queue's message register. A receiver takes the oldest word by reading that same register. Each queue also has two read-only registers, one that reports whether the queue is full and one that reports how many words it holds.

Each queue produces two events. The new-message event means that words are waiting. The refill event means that room has opened in a queue that was full. Each interrupt user has its own sticky status register and its own enable mask, so any user can watch any mix of queues. A user's interrupt line is the OR of its enabled status bits. The register layout for the users comes in two variants, picked by a parameter. In the first, a single enable register is written directly. In the second, separate set and clear registers let software change single enable bits without a read-modify-write.

All bus accesses complete in one cycle. Read data is valid in the same cycle as the read. A pop or push takes effect at the clock edge that ends the access.

Top module: `ipc_mailbox`

## Requirements
- R1: After reset every queue is empty and not full, every status and enable bit is zero, every irq line is low, and offset 0x000 reads the REVISION parameter.
- R2: A write to offset 0x040+4*m appends the word to queue m. A read there returns the oldest word and removes it, so words leave in the order they entered, including across pointer wrap.
- R3: A queue holds DEPTH (default 4) words. While full, offset 0x080+4*m reads 1, otherwise 0. A write to a full queue is dropped and leaves count and contents unchanged.
- R4: Offset 0x0C0+4*m reads the number of stored words. A read of an empty queue's message register returns 0 and changes nothing.
- R5: In every user's status and enable registers, bit 2*m belongs to the new-message event of queue m and bit 2*m+1 belongs to its refill event.
- R6: The new-message status bit sets on every accepted push. While the queue still holds words, the bit stays set even when software clears it. Once the queue is empty, a clear removes it.
- R7: The refill status bit sets when a word is popped from a full queue.
- R8: Status bits are cleared by writing 1. Bits written as 0 keep their value, and a status bit drops only through such a clear.
- R9: irq[u] is high exactly when user u has a bit set in both its status and its enable register.
- R10: With LAYOUT=1, user u's status sits at 0x100+8*u and its enable at 0x104+8*u. A write to the enable register replaces the whole mask.
- R11: With LAYOUT=2, user u's status sits at 0x104+0x10*u, enable-set at 0x108+0x10*u and enable-clear at 0x10C+0x10*u. Writing ones to enable-set turns those bits on. Writing ones to enable-clear turns them off. Both registers read back the current mask.
- R12: Offsets that map to nothing read 0 and ignore writes. Writes to the revision, full and count registers have no effect.
- R13: Each user keeps its own status register. A clear by one user leaves the other users' status bits untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Bus access in this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 12 | Byte offset of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid in the cycle of the read |
| irq | output | NUM_USERS | One interrupt line per user |

## Verification
The assertions assume that the bus carries at most one access per cycle. This means a queue never sees a push and a pop in the same cycle, and an enable-set and an enable-clear never happen together. The bench drives each access for exactly one cycle and then holds busSel low, so it stays within that assumption. It uses word-aligned offsets, except where it probes unmapped space on purpose.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;
  localparam int IDX_W = 4;  // up to 16 queues
  localparam logic [ADDR_W-1:0] MSG_BASE  = 12'h040;
  localparam logic [ADDR_W-1:0] FULL_BASE = 12'h080;
  localparam logic [ADDR_W-1:0] CNT_BASE  = 12'h0C0;

  typedef struct packed {
    logic              push;
    logic              pop;
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] data;
  } mboxStrobe_t;
endpackage

// File: rtl/mbox_fifo.sv
module mbox_fifo #(
  parameter int DEPTH = 4,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pushReq,
  input  logic              popReq,
  input  logic [31:0]       pushData,
  output logic [31:0]       headData,
  output logic [CNT_W-1:0]  count,
  output logic              isFull,
  output logic              notEmpty,
  output logic              pushDone,
  output logic              popFromFull
);
  logic [31:0]      mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic             popDone;

  assign isFull      = (count == CNT_W'(DEPTH));
  assign notEmpty    = (count != '0);
  assign pushDone    = pushReq && !isFull;
  assign popDone     = popReq && notEmpty;
  assign popFromFull = popDone && isFull;
  assign headData    = notEmpty ? mem[rdPtr] : '0;

  function automatic logic [PTR_W-1:0] bump(logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (pushDone) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (pushDone) wrPtr <= bump(wrPtr);
      if (popDone)  rdPtr <= bump(rdPtr);
      count <= count + CNT_W'(pushDone) - CNT_W'(popDone);
    end
  end

  // R3
  full_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    pushReq && isFull && !popReq |=> count == $past(count));
  // R3
  count_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(DEPTH));
  // R4
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rstN)
    popReq && !notEmpty && !pushReq |=> count == '0);
  // R2
  push_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    pushReq && !isFull && !popReq |=> count == $past(count) + 1'b1);
endmodule

// File: rtl/mbox_datapath.sv
module mbox_datapath
  import mbox_pkg::*;
#(
  parameter int NUM_FIFOS = 4,
  parameter int DEPTH = 4,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  mboxStrobe_t          strobe,
  output logic [31:0]          headData [NUM_FIFOS],
  output logic [CNT_W-1:0]     count [NUM_FIFOS],
  output logic [NUM_FIFOS-1:0] full,
  output logic [NUM_FIFOS-1:0] notEmpty,
  output logic [NUM_FIFOS-1:0] pushEvt,
  output logic [NUM_FIFOS-1:0] refillEvt
);
  for (genvar m = 0; m < NUM_FIFOS; m++) begin : gQueue
    logic hit;
    assign hit = (strobe.idx == IDX_W'(m));
    mbox_fifo #(.DEPTH(DEPTH)) uQueue (
      .clk        (clk),
      .rstN       (rstN),
      .pushReq    (strobe.push && hit),
      .popReq     (strobe.pop && hit),
      .pushData   (strobe.data),
      .headData   (headData[m]),
      .count      (count[m]),
      .isFull     (full[m]),
      .notEmpty   (notEmpty[m]),
      .pushDone   (pushEvt[m]),
      .popFromFull(refillEvt[m])
    );
  end
endmodule

// File: rtl/mbox_ctrl.sv
module mbox_ctrl
  import mbox_pkg::*;
#(
  parameter int NUM_FIFOS = 4,
  parameter int NUM_USERS = 2,
  parameter int LAYOUT = 1,
  parameter int DEPTH = 4,
  parameter logic [31:0] REVISION = 32'h0000_0102,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int EVT_W = 2 * NUM_FIFOS
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 busSel,
  input  logic                 busWrite,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic [31:0]          busWdata,
  output logic [31:0]          busRdata,
  output logic [NUM_USERS-1:0] irq,
  output mboxStrobe_t          strobe,
  input  logic [31:0]          headData [NUM_FIFOS],
  input  logic [CNT_W-1:0]     count [NUM_FIFOS],
  input  logic [NUM_FIFOS-1:0] full,
  input  logic [NUM_FIFOS-1:0] notEmpty,
  input  logic [NUM_FIFOS-1:0] pushEvt,
  input  logic [NUM_FIFOS-1:0] refillEvt
);
  logic [EVT_W-1:0]     status [NUM_USERS];
  logic [EVT_W-1:0]     enable [NUM_USERS];
  logic [EVT_W-1:0]     statW1c [NUM_USERS];
  logic [NUM_USERS-1:0] enSetWr, enClrWr;
  logic [EVT_W-1:0]     evtVec;
  logic                 wrAcc, rdAcc;

  assign wrAcc = busSel && busWrite;
  assign rdAcc = busSel && !busWrite;

  function automatic logic [ADDR_W-1:0] statOff(int u);
    return (LAYOUT == 2) ? ADDR_W'(32'h104 + 16 * u) : ADDR_W'(32'h100 + 8 * u);
  endfunction

  always_comb begin
    for (int m = 0; m < NUM_FIFOS; m++) begin
      evtVec[2*m]   = pushEvt[m] || notEmpty[m];
      evtVec[2*m+1] = refillEvt[m];
    end
  end

  // address decode and read mux
  always_comb begin
    strobe   = '0;
    busRdata = '0;
    enSetWr  = '0;
    enClrWr  = '0;
    strobe.data = busWdata;
    for (int u = 0; u < NUM_USERS; u++) statW1c[u] = '0;
    if (busAddr == '0) busRdata = REVISION;
    for (int m = 0; m < NUM_FIFOS; m++) begin
      if (busAddr == MSG_BASE + ADDR_W'(4 * m)) begin
        strobe.idx  = IDX_W'(m);
        strobe.push = wrAcc;
        strobe.pop  = rdAcc;
        busRdata    = headData[m];
      end
      if (busAddr == FULL_BASE + ADDR_W'(4 * m)) busRdata = {31'b0, full[m]};
      if (busAddr == CNT_BASE + ADDR_W'(4 * m))  busRdata = 32'(count[m]);
    end
    for (int u = 0; u < NUM_USERS; u++) begin
      if (busAddr == statOff(u)) begin
        busRdata = 32'(status[u]);
        if (wrAcc) statW1c[u] = busWdata[EVT_W-1:0];
      end
      if (busAddr == statOff(u) + ADDR_W'(4)) begin
        busRdata   = 32'(enable[u]);
        enSetWr[u] = wrAcc;
      end
      if (LAYOUT == 2 && busAddr == statOff(u) + ADDR_W'(8)) begin
        busRdata   = 32'(enable[u]);
        enClrWr[u] = wrAcc;
      end
    end
  end

  for (genvar u = 0; u < NUM_USERS; u++) begin : gUser
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        status[u] <= '0;
        enable[u] <= '0;
      end else begin
        status[u] <= (status[u] & ~statW1c[u]) | evtVec;
        if (LAYOUT == 2) begin
          if (enSetWr[u])      enable[u] <= enable[u] | busWdata[EVT_W-1:0];
          else if (enClrWr[u]) enable[u] <= enable[u] & ~busWdata[EVT_W-1:0];
        end else if (enSetWr[u]) begin
          enable[u] <= busWdata[EVT_W-1:0];
        end
      end
    end
    assign irq[u] = |(status[u] & enable[u]);

    // R8
    w1c_only_chk: assert property (@(posedge clk) disable iff (!rstN)
      1'b1 |=> (($past(status[u]) & ~status[u] & ~$past(statW1c[u])) == '0));

    for (genvar m = 0; m < NUM_FIFOS; m++) begin : gHold
      // R6
      newmsg_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
        notEmpty[m] |=> status[u][2*m]);
    end

    if (LAYOUT == 2) begin : gSetClr
      // R11
      en_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
        enClrWr[u] |=> (enable[u] & $past(busWdata[EVT_W-1:0])) == '0);
      // R11
      en_set_chk: assert property (@(posedge clk) disable iff (!rstN)
        enSetWr[u] |=> (enable[u] & $past(busWdata[EVT_W-1:0])) == $past(busWdata[EVT_W-1:0]));
    end
  end
endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox
  import mbox_pkg::*;
#(
  parameter int NUM_FIFOS = 4,
  parameter int NUM_USERS = 2,
  parameter int LAYOUT = 1,
  parameter int DEPTH = 4,
  parameter logic [31:0] REVISION = 32'h0000_0102,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 busSel,
  input  logic                 busWrite,
  input  logic [11:0]          busAddr,
  input  logic [31:0]          busWdata,
  output logic [31:0]          busRdata,
  output logic [NUM_USERS-1:0] irq
);
  mboxStrobe_t          strobe;
  logic [31:0]          headData [NUM_FIFOS];
  logic [CNT_W-1:0]     count [NUM_FIFOS];
  logic [NUM_FIFOS-1:0] full, notEmpty, pushEvt, refillEvt;

  mbox_ctrl #(
    .NUM_FIFOS(NUM_FIFOS), .NUM_USERS(NUM_USERS), .LAYOUT(LAYOUT),
    .DEPTH(DEPTH), .REVISION(REVISION)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata), .irq(irq),
    .strobe(strobe), .headData(headData), .count(count), .full(full),
    .notEmpty(notEmpty), .pushEvt(pushEvt), .refillEvt(refillEvt)
  );

  mbox_datapath #(.NUM_FIFOS(NUM_FIFOS), .DEPTH(DEPTH)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .headData(headData),
    .count(count), .full(full), .notEmpty(notEmpty), .pushEvt(pushEvt),
    .refillEvt(refillEvt)
  );
endmodule

// File: tb/ipc_mailbox_test.sv
module ipc_mailbox_test;
  localparam logic [31:0] REV = 32'h0000_0102;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  sel = 2'b00;
  logic        wr = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata0, rdata1;
  logic [1:0]  irq0, irq1;
  int checks = 0;
  int errors = 0;
  logic [31:0] expData [$];
  string       expTag [$];
  int          expInst [$];

  always #4 clk = ~clk;

  ipc_mailbox #(.LAYOUT(1), .REVISION(REV)) uut (
    .clk(clk), .rstN(rstN), .busSel(sel[0]), .busWrite(wr), .busAddr(addr),
    .busWdata(wdata), .busRdata(rdata0), .irq(irq0));

  ipc_mailbox #(.LAYOUT(2), .REVISION(REV)) uutAlt (
    .clk(clk), .rstN(rstN), .busSel(sel[1]), .busWrite(wr), .busAddr(addr),
    .busWdata(wdata), .busRdata(rdata1), .irq(irq1));

  task automatic check(logic [31:0] act, logic [31:0] exp, string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wrReg(int inst, logic [11:0] a, logic [31:0] d);
    sel = (inst == 0) ? 2'b01 : 2'b10;
    wr = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    sel = 2'b00; wr = 1'b0;
  endtask

  // driver: queues the expected value, then issues the read
  task automatic rdReg(int inst, logic [11:0] a, logic [31:0] exp, string tag);
    expData.push_back(exp); expTag.push_back(tag); expInst.push_back(inst);
    sel = (inst == 0) ? 2'b01 : 2'b10;
    wr = 1'b0; addr = a;
    @(posedge clk); #1;
    sel = 2'b00;
  endtask

  // monitor: compares read data mid-cycle
  always @(negedge clk) begin
    if (sel != 2'b00 && !wr && expData.size() > 0) begin
      automatic int inst = expInst.pop_front();
      check(inst == 0 ? rdata0 : rdata1, expData.pop_front(), expTag.pop_front());
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    check(32'd0, 32'd1, "watchdog");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    @(posedge clk); #1;
    // reset state
    rdReg(0, 12'h000, REV, "R1 revision");
    rdReg(0, 12'h0C0, 0, "R1 count");
    rdReg(0, 12'h080, 0, "R1 full");
    rdReg(0, 12'h100, 0, "R1 status");
    rdReg(0, 12'h104, 0, "R1 enable");
    check({30'b0, irq0}, 0, "R1 irq");
    // fill queue 1
    wrReg(0, 12'h044, 32'hA1);
    wrReg(0, 12'h044, 32'hB2);
    wrReg(0, 12'h044, 32'hC3);
    rdReg(0, 12'h0C4, 3, "R4 count three");
    rdReg(0, 12'h100, 32'h4, "R5 R6 newmsg bit2");
    rdReg(0, 12'h108, 32'h4, "R13 user1 status");
    wrReg(0, 12'h044, 32'hD4);
    rdReg(0, 12'h084, 1, "R3 full flag");
    wrReg(0, 12'h044, 32'hE5);
    rdReg(0, 12'h0C4, 4, "R3 dropped write count");
    wrReg(0, 12'h104, 32'h4);
    check({31'b0, irq0[0]}, 1, "R9 R10 irq0 on");
    check({31'b0, irq0[1]}, 0, "R9 irq1 off");
    rdReg(0, 12'h044, 32'hA1, "R2 pop first");
    rdReg(0, 12'h100, 32'hC, "R7 refill bit3");
    rdReg(0, 12'h044, 32'hB2, "R2 pop second");
    rdReg(0, 12'h044, 32'hC3, "R2 pop third");
    rdReg(0, 12'h044, 32'hD4, "R2 R3 pop fourth");
    rdReg(0, 12'h044, 32'h0, "R4 empty read");
    rdReg(0, 12'h0C4, 0, "R4 empty count");
    rdReg(0, 12'h084, 0, "R3 not full");
    // clear
    wrReg(0, 12'h100, 32'h4);
    rdReg(0, 12'h100, 32'h8, "R6 R8 clear when empty");
    rdReg(0, 12'h108, 32'hC, "R13 user1 untouched");
    wrReg(0, 12'h100, 32'h0);
    rdReg(0, 12'h100, 32'h8, "R8 zero write");
    check({31'b0, irq0[0]}, 0, "R9 irq0 off");
    // re-set while non-empty
    wrReg(0, 12'h040, 32'h5A5A);
    rdReg(0, 12'h100, 32'h9, "R6 push sets bit0");
    wrReg(0, 12'h100, 32'h1);
    rdReg(0, 12'h100, 32'h9, "R6 holds while nonempty");
    rdReg(0, 12'h040, 32'h5A5A, "R2 queue0 pop");
    wrReg(0, 12'h100, 32'h1);
    rdReg(0, 12'h100, 32'h8, "R6 cleared after drain");
    // direct enable write
    wrReg(0, 12'h104, 32'h2);
    rdReg(0, 12'h104, 32'h2, "R10 enable replace");
    // unmapped and read-only
    wrReg(0, 12'h03C, 32'hFFFF);
    rdReg(0, 12'h03C, 0, "R12 unmapped");
    rdReg(0, 12'h1F0, 0, "R12 unmapped high");
    wrReg(0, 12'h0C0, 32'h3);
    rdReg(0, 12'h0C0, 0, "R12 count readonly");
    wrReg(0, 12'h000, 32'hFFFF);
    rdReg(0, 12'h000, REV, "R12 revision readonly");
    // second layout
    wrReg(1, 12'h108, 32'h5);
    wrReg(1, 12'h108, 32'h2);
    rdReg(1, 12'h108, 32'h7, "R11 set ORs");
    rdReg(1, 12'h10C, 32'h7, "R11 clear reads mask");
    wrReg(1, 12'h10C, 32'h4);
    rdReg(1, 12'h108, 32'h3, "R11 clear bits");
    rdReg(1, 12'h100, 0, "R11 R12 unmapped in layout2");
    wrReg(1, 12'h040, 32'h77);
    rdReg(1, 12'h104, 32'h1, "R11 status offset");
    rdReg(1, 12'h114, 32'h1, "R11 R13 user1 status");
    check({31'b0, irq1[0]}, 1, "R9 R11 irq user0");
    check({31'b0, irq1[1]}, 0, "R9 R11 irq user1");
    rdReg(1, 12'h040, 32'h77, "R2 layout2 pop");
    // wrap ordering on queue 2
    for (int i = 0; i < 4; i++) wrReg(1, 12'h048, 32'h100 + i);
    rdReg(1, 12'h048, 32'h100, "R2 wrap a");
    rdReg(1, 12'h048, 32'h101, "R2 wrap b");
    wrReg(1, 12'h048, 32'h104);
    wrReg(1, 12'h048, 32'h105);
    rdReg(1, 12'h0C8, 4, "R4 wrap count");
    for (int i = 2; i < 6; i++) rdReg(1, 12'h048, 32'h100 + i, "R2 wrap order");
    rdReg(1, 12'h0C8, 0, "R4 wrap drained");
    @(negedge clk); #1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule